// File: doc/BRIEF.md
# Selective High-Bit Replication Codec

This block is a combinational encoder and decoder pair for unsigned words sent across a link that may flip bits. Bit i of a word is worth 2^i, so an upset in a high bit causes a large value error and an upset in a low bit causes a small one. The codec protects only the top P bits, where corruption would exceed the error budget. The lower W-P bits are sent raw. With the defaults (W=8, P=3), a single upset anywhere in the code word moves the decoded value by at most 16, which is below the tolerated bound of 32.

The encoder places the raw low bits at the bottom of the code word. Above them it writes R identical copies of each protected bit, one group per bit, with the most significant bit's group first. The decoder rebuilds each protected bit by majority vote over its copies. It raises a per-bit flag when the copies disagree, and raises a summary flag when any per-bit flag is set. The replication factor R must be odd; 3 is the default and 5 is also supported. An upset that forces a bit to the value it already holds is masked: it changes nothing and raises no flag.

Top module: `smp_codec`

## Requirements
- R1: Code word bits 0 to W-P-1 carry data bits 0 to W-P-1 unchanged, and the code word is (W-P)+P*R bits wide.
- R2: Data bit W-1-j (j=0 is the MSB) appears R times, at code positions (W-P)+j*R through (W-P)+j*R+R-1.
- R3: The decoder passes code bits 0 to W-P-1 straight to data bits 0 to W-P-1, even when those bits are corrupted.
- R4: Each protected output bit is the majority value of its R copies, so it stays exact while at most (R-1)/2 of its copies are wrong.
- R5: Mismatch flag k (for data bit W-P+k) is 1 exactly when the copies for that bit are not all equal.
- R6: The corrected-error output is the OR of all mismatch flags.
- R7: An upset that leaves a bit at its current value is masked: the decoded word equals the sent word and no flag is raised.
- R8: Any single-bit flip in a code word decodes to a value within 2^(W-P-1) of the sent value.
- R9: Elaboration fails when R is even, when P is greater than W, or when P is less than 1.
- R10: With R=5, two flipped copies in one group still decode to the sent value, and that group's flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_in | input | W | Word to encode |
| code_out | output | (W-P)+P*R | Encoded word |
| code_in | input | (W-P)+P*R | Received, possibly corrupted, code word |
| data_out | output | W | Decoded word |
| mismatch | output | P | Per protected bit: copies disagree |
| corrected_error | output | 1 | OR of the mismatch flags |

## Verification
Both paths are pure logic, so every output is valid in the same cycle its input changes; no result is due on a later clock edge. The bench drives inputs just after a falling clock edge and samples the outputs 1 ns later, before the next rising edge, so only settled values are compared. The bench computes expected code words and decoded values from the layout rules, on its own. It sweeps every 8-bit value with every single-bit flip, and also applies masked upsets and double flips to a copy built with R=5.

// File: rtl/smp_pkg.sv
// Package: shared helpers for the selective replication codec.
// Assumes callers pass an odd replication factor.
package smp_pkg;
    // Width of a code word for the given data width, protected count and factor.
    function automatic int code_width(input int w, input int p, input int r);
        return (w - p) + p * r;
    endfunction
endpackage

// File: rtl/smp_vote.sv
// Module: majority voter for one protected bit.
// Takes R copies of the bit. Outputs the majority value, and a flag when the
// copies are not all equal. Assumes R is odd, so a tie cannot happen.
module smp_vote #(
    parameter int R = 3
) (
    input  logic [R-1:0] copies,
    output logic         bit_o,
    output logic         disagree
);
    localparam int HALF = R / 2;

    // Count the ones, pick the majority, and detect any disagreement.
    always_comb begin
        int ones;
        ones = 0;
        for (int c = 0; c < R; c++) begin
            ones = ones + int'(copies[c]);
        end
        bit_o    = (ones > HALF);
        disagree = (ones != 0) && (ones != R);
    end
endmodule

// File: rtl/smp_encoder.sv
// Module: encoder. Writes the raw low bits, then R copies of each protected
// bit, with the MSB group lowest. Assumes 1 <= P <= W.
module smp_encoder #(
    parameter int W = 8,
    parameter int P = 3,
    parameter int R = 3
) (
    input  logic [W-1:0]                          data_in,
    output logic [smp_pkg::code_width(W,P,R)-1:0] code_out
);
    localparam int U = W - P;

    generate
        if (U > 0) begin : g_raw
            // Raw low bits go straight across.
            assign code_out[U-1:0] = data_in[U-1:0];
        end
        for (genvar j = 0; j < P; j++) begin : g_grp
            // Group j holds R copies of data bit W-1-j.
            assign code_out[U + j*R +: R] = {R{data_in[W-1-j]}};
        end
    endgenerate
endmodule

// File: rtl/smp_decoder.sv
// Module: decoder. Passes the raw low bits through and votes each
// protected group. Assumes the code layout produced by smp_encoder.
module smp_decoder #(
    parameter int W = 8,
    parameter int P = 3,
    parameter int R = 3
) (
    input  logic [smp_pkg::code_width(W,P,R)-1:0] code_in,
    output logic [W-1:0]                          data_out,
    output logic [P-1:0]                          mismatch
);
    localparam int U = W - P;

    generate
        if (U > 0) begin : g_raw
            // Low bits are unprotected and copied as received.
            assign data_out[U-1:0] = code_in[U-1:0];
        end
        for (genvar j = 0; j < P; j++) begin : g_vote
            // One voter per protected bit; its flag is indexed from the lowest protected bit.
            smp_vote #(.R(R)) vote_i (
                .copies   (code_in[U + j*R +: R]),
                .bit_o    (data_out[W-1-j]),
                .disagree (mismatch[P-1-j])
            );
        end
    endgenerate
endmodule

// File: rtl/smp_codec.sv
// Module: top of the selective high-bit replication codec.
// The encode and decode paths are independent and purely combinational.
// Assumes R odd and 1 <= P <= W; elaboration stops otherwise.
module smp_codec #(
    parameter int W = 8,
    parameter int P = 3,
    parameter int R = 3
) (
    input  logic [W-1:0]                 data_in,
    output logic [(W-P)+P*R-1:0]         code_out,
    input  logic [(W-P)+P*R-1:0]         code_in,
    output logic [W-1:0]                 data_out,
    output logic [P-1:0]                 mismatch,
    output logic                         corrected_error
);
    // R9: reject illegal parameter sets at elaboration.
    generate
        if ((R % 2) == 0) begin : g_bad_r
            $error("smp_codec: replication factor must be odd");
        end
        if (P > W || P < 1) begin : g_bad_p
            $error("smp_codec: protected bit count out of range");
        end
    endgenerate

    smp_encoder #(.W(W), .P(P), .R(R)) enc_i (
        .data_in  (data_in),
        .code_out (code_out)
    );

    smp_decoder #(.W(W), .P(P), .R(R)) dec_i (
        .code_in  (code_in),
        .data_out (data_out),
        .mismatch (mismatch)
    );

    // R6: summary of all group flags.
    assign corrected_error = |mismatch;
endmodule

// File: rtl/smp_codec_chk.sv
// Module: checker for smp_codec, watching its ports only.
// Uses immediate assertions because the block has no state.
module smp_codec_chk #(
    parameter int W = 8,
    parameter int P = 3,
    parameter int R = 3
) (
    input logic [W-1:0]         data_in,
    input logic [(W-P)+P*R-1:0] code_out,
    input logic [(W-P)+P*R-1:0] code_in,
    input logic [W-1:0]         data_out,
    input logic [P-1:0]         mismatch,
    input logic                 corrected_error
);
    localparam int U = W - P;

    // Check the encoder groups, the flag summary and the vote agreement.
    always_comb begin
        for (int j = 0; j < P; j++) begin
            for (int c = 0; c < R; c++) begin
                a_r2_copy_matches_msb: assert (code_out[U + j*R + c] == data_in[W-1-j])
                    else $error("copy mismatch group %0d", j);
            end
            // R4: with no disagreement the output bit equals every copy.
            a_r4_agree_pass: assert (mismatch[P-1-j] || (data_out[W-1-j] == code_in[U + j*R]))
                else $error("agreeing group %0d decoded wrong", j);
            // R5: a raised flag means the copies differ.
            a_r5_flag_real: assert (!mismatch[P-1-j] ||
                                    (code_in[U + j*R +: R] != {R{1'b0}} && code_in[U + j*R +: R] != {R{1'b1}}))
                else $error("flag without disagreement group %0d", j);
        end
        a_r6_summary: assert (corrected_error == (mismatch != '0))
            else $error("summary flag wrong");
    end
endmodule

bind smp_codec smp_codec_chk #(.W(W), .P(P), .R(R)) chk_i (
    .data_in         (data_in),
    .code_out        (code_out),
    .code_in         (code_in),
    .data_out        (data_out),
    .mismatch        (mismatch),
    .corrected_error (corrected_error)
);

// File: tb/smp_codec_tb_top.sv
// Bench: directed scenarios, one task each, for smp_codec at R=3 and R=5.
module smp_codec_tb_top;
    localparam int W  = 8;
    localparam int P  = 3;
    localparam int U  = W - P;
    localparam int C3 = U + P*3;
    localparam int C5 = U + P*5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;

    logic [W-1:0]  d3_in, d3_out, d5_in, d5_out;
    logic [C3-1:0] c3_out, c3_in;
    logic [C5-1:0] c5_out, c5_in;
    logic [P-1:0]  m3, m5;
    logic          e3, e5;

    smp_codec #(.W(W), .P(P), .R(3)) dut_i (
        .data_in(d3_in), .code_out(c3_out), .code_in(c3_in),
        .data_out(d3_out), .mismatch(m3), .corrected_error(e3));

    smp_codec #(.W(W), .P(P), .R(5)) dut5_i (
        .data_in(d5_in), .code_out(c5_out), .code_in(c5_in),
        .data_out(d5_out), .mismatch(m5), .corrected_error(e5));

    // Record one check and report a failure line.
    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference encoder built from R1 and R2.
    function automatic logic [C5-1:0] ref_enc(input logic [W-1:0] d, input int r);
        logic [C5-1:0] c;
        c = '0;
        for (int i = 0; i < U; i++) c[i] = d[i];
        for (int j = 0; j < P; j++)
            for (int k = 0; k < r; k++) c[U + j*r + k] = d[W-1-j];
        return c;
    endfunction

    // Drive the inputs after a falling edge and let them settle.
    task automatic apply3(input logic [W-1:0] d, input logic [C3-1:0] c);
        @(negedge clk);
        d3_in = d; c3_in = c;
        #1;
    endtask

    task automatic apply5(input logic [W-1:0] d, input logic [C5-1:0] c);
        @(negedge clk);
        d5_in = d; c5_in = c;
        #1;
    endtask

    // Reset state: zero in gives zero out, no flags.
    task automatic t_reset();
        apply3('0, '0);
        chk(c3_out == '0, "R1 zero code", c3_out, 0);
        chk(d3_out == '0 && e3 == 1'b0, "R6 zero decode", {e3, d3_out}, 0);
    endtask

    // R1 and R2: the encoder layout over every data value.
    task automatic t_layout();
        for (int v = 0; v < 256; v++) begin
            logic [C3-1:0] e;
            e = C3'(ref_enc(W'(v), 3));
            apply3(W'(v), e);
            chk(c3_out == e, "R1 R2 layout", c3_out, e);
            chk(d3_out == W'(v) && m3 == '0, "R4 clean roundtrip", d3_out, v);
        end
    endtask

    // Every single flip on every value: R3, R4, R5, R6, R8.
    task automatic t_flips();
        for (int v = 0; v < 256; v++) begin
            for (int b = 0; b < C3; b++) begin
                logic [C3-1:0] c;
                logic [P-1:0]  em;
                int            dev;
                c = C3'(ref_enc(W'(v), 3)) ^ (C3'(1) << b);
                apply3(W'(v), c);
                dev = (int'(d3_out) > v) ? int'(d3_out) - v : v - int'(d3_out);
                chk(dev <= (1 << (U-1)), "R8 deviation bound", dev, 1 << (U-1));
                chk(d3_out[W-1:U] == W'(v) >> U, "R4 protected exact", d3_out[W-1:U], v >> U);
                em = '0;
                if (b >= U) em[P-1-(b-U)/3] = 1'b1;
                chk(m3 == em, "R5 flag position", m3, em);
                chk(e3 == (b >= U), "R6 summary", e3, b >= U);
                if (b < U)
                    chk(d3_out == (W'(v) ^ (W'(1) << b)), "R3 raw low bit", d3_out, W'(v) ^ (W'(1) << b));
            end
        end
    endtask

    // R7: forcing each bit to its present value changes nothing.
    task automatic t_masked();
        for (int v = 0; v < 256; v += 37) begin
            for (int b = 0; b < C3; b++) begin
                logic [C3-1:0] c;
                c = C3'(ref_enc(W'(v), 3));
                c[b] = c[b];
                apply3(W'(v), c);
                chk(d3_out == W'(v) && !e3, "R7 masked upset", {e3, d3_out}, v);
            end
        end
    endtask

    // R10: R=5 survives two flips inside one group.
    task automatic t_double5();
        for (int v = 0; v < 256; v += 17) begin
            for (int j = 0; j < P; j++) begin
                logic [C5-1:0] c;
                logic [P-1:0]  em;
                c = ref_enc(W'(v), 5);
                apply5(W'(v), c);
                chk(c5_out == c, "R2 layout R5", c5_out, c);
                c[U + j*5]     = ~c[U + j*5];
                c[U + j*5 + 3] = ~c[U + j*5 + 3];
                apply5(W'(v), c);
                em = '0; em[P-1-j] = 1'b1;
                chk(d5_out == W'(v), "R10 double flip value", d5_out, v);
                chk(m5 == em && e5, "R10 double flip flag", m5, em);
            end
        end
    endtask

    // Watchdog: a hung run counts as one failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        d3_in = '0; c3_in = '0; d5_in = '0; c5_in = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset();
        t_layout();
        t_flips();
        t_masked();
        t_double5();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule